// File: doc/BRIEF.md
# Serial Strobed Register Slave

This block is a small register file on the device side of a three-wire serial link. The link has a serial clock, a data-in line and a data-out line, plus an active-low strobe. There is no chip select around a command. The host shifts bits into a plain shift register while the strobe is high. It then lowers the strobe and gives one serial clock pulse. The data-in level at that pulse says whether the command is a write or a read. A write commits the shifted data word to the shifted address. A read loads the addressed register into an output shifter, and the host clocks that shifter out on data-out.

The register set has five entries:

- a mode word and a mux word, both writable and both driven out on pins;
- a read-only view of an external switch bus;
- a reset control whose bit 0 starts a CPU reset pulse of fixed length;
- a read-only version constant.

The serial pins come from another clock domain. Each one is brought into the system clock through a two-flop synchronizer, and its edges are detected there. The link therefore carries no data stream with back-pressure. The host paces every bit, and it must hold each line level for several system clocks.

Top module: `ssr_slave`

## Requirements
- R1: After reset, mode_o and mux_o are zero, cpu_reset_o is low and ser_dout_o is high.
- R2: While ser_stb_n_i is high, each rising edge of ser_clk_i shifts ser_din_i MSB first into a 40-bit frame that keeps only the most recent 40 bits. The frame's upper 32 bits are the data word and its lower 8 bits are the address. Bits sent before the last 40 have no effect.
- R3: A rising edge of ser_clk_i while ser_stb_n_i is low issues one command. If ser_din_i is 1 at that edge the command is a write; if it is 0 the command is a read. The frame does not shift during that edge.
- R4: A write to address 0x00 loads the data word into mode_o, and a write to address 0x02 loads it into mux_o. A read of either address returns the value written.
- R5: Writes to address 0x08, to address 0xFF and to any unmapped address change no register. mode_o, mux_o and every read value stay as they were.
- R6: A read command loads the addressed 32-bit value into the output shifter, and ser_dout_o shows its MSB at once. Each falling edge of ser_clk_i while ser_stb_n_i is high moves the next bit out. Ones fill in behind the word, so after 32 bits ser_dout_o reads 1.
- R7: A read of 0x08 returns the synchronized switch_i bus, a read of 0xFF returns the VERSION parameter, and a read of an unmapped address returns zero.
- R8: A write to 0x80 with data bit 0 set drives cpu_reset_o high for exactly RST_CYCLES system clocks, after which the bit clears itself. A write to 0x80 with bit 0 clear has no effect. A read of 0x80 returns the current reset bit in bit 0 and zeros above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock from host, idle low |
| ser_din_i | input | 1 | Serial data from host, idle low |
| ser_stb_n_i | input | 1 | Active-low command strobe, idle high |
| switch_i | input | 32 | External switch bus, asynchronous |
| ser_dout_o | output | 1 | Serial data to host, MSB first |
| mode_o | output | 32 | Mode register contents |
| mux_o | output | 32 | Mux register contents |
| cpu_reset_o | output | 1 | CPU reset pulse, active high |

## Verification
The hardest case to reach from the pins is a frame that is longer than 40 bits. Only the last 40 bits may take effect, and a shift-register slip would corrupt the address or the data without breaking simple transfers. The bench covers this by sending junk bits ahead of a normal write and then reading back the value. It also measures the exact length of the reset pulse by counting system clocks at the pin. Finally, it writes every read-only and unmapped address with distinct patterns and reads back each register that could have been hit.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int SSR_ADDR_W = 8;
  localparam int SSR_DATA_W = 32;

  localparam logic [SSR_ADDR_W-1:0] ADR_MODE    = 8'h00;
  localparam logic [SSR_ADDR_W-1:0] ADR_MUX     = 8'h02;
  localparam logic [SSR_ADDR_W-1:0] ADR_SWITCH  = 8'h08;
  localparam logic [SSR_ADDR_W-1:0] ADR_RSTCTL  = 8'h80;
  localparam logic [SSR_ADDR_W-1:0] ADR_VERSION = 8'hFF;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ssr_frontend.sv
module ssr_frontend #(
  parameter int ADDR_W = ssr_pkg::SSR_ADDR_W,
  parameter int DATA_W = ssr_pkg::SSR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_din,
  input  logic              s_stb_n,
  output logic              cmd_wr,
  output logic              cmd_rd,
  output logic              tx_shift,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  logic               clk_d;
  logic [FRAME_W-1:0] frame_q;
  logic               rise, fall;

  assign rise = s_clk & ~clk_d;
  assign fall = ~s_clk & clk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d    <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_rd   <= 1'b0;
      tx_shift <= 1'b0;
      frame_q  <= '0;
    end else begin
      clk_d    <= s_clk;
      cmd_wr   <= rise & ~s_stb_n & s_din;
      cmd_rd   <= rise & ~s_stb_n & ~s_din;
      tx_shift <= fall & s_stb_n;
      if (rise && s_stb_n) frame_q <= {frame_q[FRAME_W-2:0], s_din};
    end
  end

  assign cmd_addr = frame_q[ADDR_W-1:0];
  assign cmd_data = frame_q[FRAME_W-1:ADDR_W];
endmodule

// File: rtl/ssr_regfile.sv
module ssr_regfile #(
  parameter int ADDR_W = ssr_pkg::SSR_ADDR_W,
  parameter int DATA_W = ssr_pkg::SSR_DATA_W,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] switch_s,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              cpu_reset_o
);
  import ssr_pkg::*;

  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

  logic [DATA_W-1:0] mode_q, mux_q;
  logic              rst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hit_mode, hit_mux, hit_rst;

  assign hit_mode = cmd_wr && (cmd_addr == ADR_MODE);
  assign hit_mux  = cmd_wr && (cmd_addr == ADR_MUX);
  assign hit_rst  = cmd_wr && (cmd_addr == ADR_RSTCTL) && cmd_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mux_q  <= '0;
    end else begin
      if (hit_mode) mode_q <= cmd_data;
      if (hit_mux)  mux_q  <= cmd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      cnt_q <= '0;
    end else if (hit_rst) begin
      rst_q <= 1'b1;
      cnt_q <= CNT_LOAD;
    end else if (rst_q) begin
      if (cnt_q == '0) rst_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    case (cmd_addr)
      ADR_MODE:    rd_data = mode_q;
      ADR_MUX:     rd_data = mux_q;
      ADR_SWITCH:  rd_data = switch_s;
      ADR_RSTCTL:  rd_data = {{(DATA_W-1){1'b0}}, rst_q};
      ADR_VERSION: rd_data = VERSION;
      default:     rd_data = '0;
    endcase
  end

  assign mode_o      = mode_q;
  assign mux_o       = mux_q;
  assign cpu_reset_o = rst_q;
endmodule

// File: rtl/ssr_txshift.sv
module ssr_txshift #(
  parameter int DATA_W = ssr_pkg::SSR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              dout
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '1;
    else if (load)  sh_q <= load_val;
    else if (shift) sh_q <= {sh_q[DATA_W-2:0], 1'b1};
  end

  assign dout = sh_q[DATA_W-1];
endmodule

// File: rtl/ssr_slave.sv
module ssr_slave #(
  parameter int ADDR_W = ssr_pkg::SSR_ADDR_W,
  parameter int DATA_W = ssr_pkg::SSR_DATA_W,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203,
  parameter int RST_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  input  logic              ser_stb_n_i,
  input  logic [DATA_W-1:0] switch_i,
  output logic              ser_dout_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              cpu_reset_o
);
  logic              s_clk, s_din, s_stb_n;
  logic [DATA_W-1:0] switch_s;
  logic              cmd_wr, cmd_rd, tx_shift;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data, rd_data;

  ssr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(ser_clk_i), .q(s_clk));
  ssr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d(ser_din_i), .q(s_din));
  ssr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d(ser_stb_n_i), .q(s_stb_n));
  ssr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_sw (
    .clk(clk), .rst_n(rst_n), .d(switch_i), .q(switch_s));

  ssr_frontend #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst_n(rst_n), .s_clk(s_clk), .s_din(s_din), .s_stb_n(s_stb_n),
    .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .tx_shift(tx_shift),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  ssr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION),
                .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .switch_s(switch_s), .rd_data(rd_data),
    .mode_o(mode_o), .mux_o(mux_o), .cpu_reset_o(cpu_reset_o));

  ssr_txshift #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(cmd_rd), .load_val(rd_data),
    .shift(tx_shift), .dout(ser_dout_o));
endmodule

// File: rtl/ssr_slave_chk.sv
module ssr_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              cmd_rd,
  input logic              tx_shift,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              ser_dout_o,
  input logic [DATA_W-1:0] mode_o,
  input logic [DATA_W-1:0] mux_o,
  input logic              cpu_reset_o
);
  import ssr_pkg::*;

  logic rst_req;
  int   hi_cnt;

  assign rst_req = cmd_wr && (cmd_addr == ADR_RSTCTL) && cmd_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= 0;
    else if (rst_req)    hi_cnt <= 0;
    else if (cpu_reset_o) hi_cnt <= hi_cnt + 1;
  end

  assert_mode_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_addr == ADR_MODE) |=> (mode_o == $past(cmd_data)));
  assert_mux_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_addr == ADR_MUX) |=> (mux_o == $past(cmd_data)));
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && cmd_addr == ADR_MODE) |=> $stable(mode_o));
  assert_mux_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && cmd_addr == ADR_MUX) |=> $stable(mux_o));
  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rd && !tx_shift) |=> $stable(ser_dout_o));
  assert_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset_o) |-> $past(rst_req));
  assert_rst_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset_o |-> (hi_cnt < RST_CYCLES));
  assert_rst_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset_o) |-> (hi_cnt == RST_CYCLES));
  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && cmd_rd));
endmodule

bind ssr_slave ssr_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .tx_shift(tx_shift),
  .cmd_addr(cmd_addr), .cmd_data(cmd_data), .ser_dout_o(ser_dout_o),
  .mode_o(mode_o), .mux_o(mux_o), .cpu_reset_o(cpu_reset_o));

// File: tb/ssr_slave_tb_top.sv
module ssr_slave_tb_top;
  localparam logic [31:0] VER  = 32'hC0DE_0042;
  localparam int          RSTN = 24;
  localparam int          HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_din = 1'b0, ser_stb_n = 1'b1;
  logic [31:0] switch_in = 32'h0;
  logic        ser_dout, cpu_reset;
  logic [31:0] mode_w, mux_w;

  int checks = 0, failures = 0;
  int run_len = 0, last_len = 0, pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ssr_slave #(.VERSION(VER), .RST_CYCLES(RSTN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_din_i(ser_din),
    .ser_stb_n_i(ser_stb_n), .switch_i(switch_in), .ser_dout_o(ser_dout),
    .mode_o(mode_w), .mux_o(mux_w), .cpu_reset_o(cpu_reset));

  always @(negedge clk) begin
    if (cpu_reset) run_len++;
    else if (run_len != 0) begin
      last_len = run_len;
      pulses++;
      run_len = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clk();
    ser_clk = 1'b1; wt(HALF);
    ser_clk = 1'b0; wt(HALF);
  endtask

  task automatic shift_bit(logic b);
    ser_din = b; wt(HALF);
    pulse_clk();
  endtask

  task automatic strobe(logic wr);
    ser_din = wr; wt(HALF);
    ser_stb_n = 1'b0; wt(HALF);
    pulse_clk();
    ser_stb_n = 1'b1; ser_din = 1'b0; wt(HALF);
  endtask

  task automatic write_reg(logic [7:0] a, logic [31:0] d);
    for (int i = 31; i >= 0; i--) shift_bit(d[i]);
    for (int i = 7; i >= 0; i--) shift_bit(a[i]);
    strobe(1'b1);
  endtask

  task automatic read_reg(logic [7:0] a, output logic [31:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(a[i]);
    strobe(1'b0);
    for (int i = 31; i >= 0; i--) begin
      v[i] = ser_dout;
      pulse_clk();
    end
  endtask

  task automatic t_reset();
    chk("R1 mode_o", mode_w, 32'h0);
    chk("R1 mux_o", mux_w, 32'h0);
    chk("R1 cpu_reset_o", {31'h0, cpu_reset}, 32'h0);
    chk("R1 ser_dout_o", {31'h0, ser_dout}, 32'h1);
  endtask

  task automatic t_version();
    logic [31:0] v;
    read_reg(8'hFF, v);
    chk("R7 version read", v, VER);
    chk("R6 dout tail ones", {31'h0, ser_dout}, 32'h1);
  endtask

  task automatic t_mode_mux();
    logic [31:0] v;
    write_reg(8'h00, 32'h8123_4567);
    chk("R4 mode_o after write (R3 write dir)", mode_w, 32'h8123_4567);
    write_reg(8'h02, 32'h5A5A_F00F);
    chk("R4 mux_o after write", mux_w, 32'h5A5A_F00F);
    chk("R4 mode_o kept by mux write", mode_w, 32'h8123_4567);
    read_reg(8'h00, v);
    chk("R4 mode readback (R6 MSB first)", v, 32'h8123_4567);
    read_reg(8'h02, v);
    chk("R4 mux readback", v, 32'h5A5A_F00F);
    chk("R3 read does not write mux", mux_w, 32'h5A5A_F00F);
  endtask

  task automatic t_long_frame();
    logic [31:0] v;
    for (int i = 0; i < 11; i++) shift_bit(i[0]);
    write_reg(8'h00, 32'h0F1E_2D3C);
    chk("R2 mode_o after junk-led frame", mode_w, 32'h0F1E_2D3C);
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    read_reg(8'h02, v);
    chk("R2 read uses last 8 bits", v, 32'h5A5A_F00F);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    switch_in = 32'hA5C3_0F96; wt(4);
    write_reg(8'h08, 32'h1111_1111);
    write_reg(8'hFF, 32'h2222_2222);
    write_reg(8'h01, 32'h3333_3333);
    write_reg(8'h40, 32'h4444_4444);
    chk("R5 mode_o unchanged", mode_w, 32'h0F1E_2D3C);
    chk("R5 mux_o unchanged", mux_w, 32'h5A5A_F00F);
    chk("R5 reset not triggered", pulses, 0);
    read_reg(8'h08, v);
    chk("R7 switch read (R5 unaffected)", v, 32'hA5C3_0F96);
    read_reg(8'hFF, v);
    chk("R5 version unchanged", v, VER);
    read_reg(8'h01, v);
    chk("R7 unmapped reads zero", v, 32'h0);
  endtask

  task automatic t_reset_pulse();
    logic [31:0] v;
    write_reg(8'h80, 32'h0000_0000);
    wt(RSTN + 8);
    chk("R8 bit0 clear gives no pulse", pulses, 0);
    write_reg(8'h80, 32'hFFFF_FFFF);
    wt(RSTN + 8);
    chk("R8 one pulse", pulses, 1);
    chk("R8 pulse length", last_len, RSTN);
    chk("R8 cpu_reset_o low after", {31'h0, cpu_reset}, 32'h0);
    read_reg(8'h80, v);
    chk("R8 reset bit self-cleared", v, 32'h0);
    chk("R8 mode_o untouched", mode_w, 32'h0F1E_2D3C);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_version();
    t_mode_mux();
    t_long_frame();
    t_readonly();
    t_reset_pulse();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule